// File: doc/BRIEF.md
# Ping-Pong Load-and-Add Stream Stage

This block is one stage of a load-then-compute pipeline. It holds two equal memory banks. Each invocation does two jobs at once. It fills one bank with words taken from a ready/valid input stream. It also reads the other bank in address order, adds an operand to every word and sends the sums out on a ready/valid output stream. The sums go straight to the output and are never written back into a bank.

Control software starts an invocation with a one-cycle `start` pulse. With that pulse it supplies the least significant bit of a running invocation number and the operand for the add. That bit alone decides which bank fills and which bank drains. Sequencing therefore stays with the caller, and two invocations with the same parity reuse the same bank roles. The block raises `done` for one cycle once the full invocation has moved in and out. The very first drain reads a bank that was never loaded, and the block sends those words anyway.

Top module: `pingpong_addbuf`

## Requirements
- R1: After reset, `busy`, `done`, `s_ready` and `m_valid` are all low.
- R2: When `inv_lsb` is 0 at start, input words fill bank 0 while bank 1 drains. When it is 1, bank 1 fills while bank 0 drains. Word i of the input is stored at address i, and output word i comes from address i of the draining bank.
- R3: Every output word equals the stored word plus the invocation's operand, computed as DATA_W-bit two's-complement addition with wraparound.
- R4: Each invocation accepts exactly DEPTH input words and emits exactly DEPTH output words. `s_ready` stays low once DEPTH words have been accepted.
- R5: An input word is taken only in a cycle where both `s_valid` and `s_ready` are high.
- R6: While `m_valid` is high and `m_ready` is low, `m_valid` stays high and `m_data` holds its value into the next cycle.
- R7: `done` is high for exactly one cycle. It comes only after all DEPTH words are accepted and all DEPTH words are sent, and `busy` is low from that cycle on.
- R8: A `start` pulse while `busy` is high is ignored. It neither restarts nor alters the running invocation.
- R9: `inv_lsb` and `operand` are captured at start. Changing them during an invocation has no effect on that invocation.
- R10: Fill and drain run concurrently at one word per clock. With the input always valid and the output always ready, `done` follows start within DEPTH+4 cycles.
- R11: Draining a bank does not modify it. Two consecutive invocations of the same parity drain the same stored data, each with its own operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an invocation when idle |
| inv_lsb | input | 1 | Least significant bit of the invocation number; selects bank roles |
| operand | input | DATA_W | Value added to every drained word |
| busy | output | 1 | Invocation in progress |
| done | output | 1 | One-cycle end-of-invocation pulse |
| s_data | input | DATA_W | Input stream data |
| s_valid | input | 1 | Input stream valid |
| s_ready | output | 1 | Input stream ready |
| m_data | output | DATA_W | Output stream data (stored word + operand) |
| m_valid | output | 1 | Output stream valid |
| m_ready | input | 1 | Output stream ready |

## Verification
The stage runs through five invocations with parities even, odd, even, odd, odd. The stream conditions differ between them: both sides at full rate, pseudo-random gaps on the input valid, pseudo-random stalls on the output ready, and both at once. The full-rate runs bound the latency and show that fill and drain overlap. The gapped runs would expose a word taken without valid, a dropped stall, or a misaligned address. The operands include all-ones and the sign bit so that the add must wrap. The two odd invocations in a row must drain the same bank contents with different operands, which shows that nothing was written back. During one invocation a stray start is sent and the index and operand inputs are changed; the stage must ignore all of this.

// File: rtl/pingpong_addbuf.sv
module pingpong_addbuf #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              inv_lsb,
  input  logic [DATA_W-1:0] operand,
  output logic              busy,
  output logic              done,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_valid,
  output logic              s_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              m_valid,
  input  logic              m_ready
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(DEPTH);

  logic [DATA_W-1:0] bank0 [DEPTH];
  logic [DATA_W-1:0] bank1 [DEPTH];

  logic              fill_sel;
  logic [DATA_W-1:0] op_q;
  logic [CW-1:0]     fill_cnt;
  logic [CW-1:0]     issue_cnt;
  logic [CW-1:0]     sent_cnt;

  wire [AW-1:0] waddr = fill_cnt[AW-1:0];
  wire [AW-1:0] raddr = issue_cnt[AW-1:0];

  assign s_ready = busy && (fill_cnt != LAST);

  wire fill_fire = s_valid && s_ready;
  wire out_fire  = m_valid && m_ready;
  wire load      = busy && (issue_cnt != LAST) && (!m_valid || m_ready);
  wire finished  = (fill_cnt == LAST) && (sent_cnt == LAST);

  wire [DATA_W-1:0] rd_word = fill_sel ? bank0[raddr] : bank1[raddr];

  always_ff @(posedge clk) begin
    if (fill_fire && !fill_sel) bank0[waddr] <= s_data;
    if (fill_fire &&  fill_sel) bank1[waddr] <= s_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      fill_sel  <= 1'b0;
      op_q      <= '0;
      fill_cnt  <= '0;
      issue_cnt <= '0;
      sent_cnt  <= '0;
      m_valid   <= 1'b0;
      m_data    <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy      <= 1'b1;
          fill_sel  <= inv_lsb;
          op_q      <= operand;
          fill_cnt  <= '0;
          issue_cnt <= '0;
          sent_cnt  <= '0;
        end
      end else begin
        if (fill_fire) fill_cnt <= fill_cnt + 1'b1;
        if (load) begin
          m_data    <= rd_word + op_q;
          m_valid   <= 1'b1;
          issue_cnt <= issue_cnt + 1'b1;
        end else if (out_fire) begin
          m_valid <= 1'b0;
        end
        if (out_fire) sent_cnt <= sent_cnt + 1'b1;
        if (finished) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pingpong_addbuf_chk.sv
module pingpong_addbuf_chk #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 1024
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              s_ready,
  input logic              m_valid,
  input logic              m_ready,
  input logic [DATA_W-1:0] m_data,
  input logic              fill_sel,
  input logic [DATA_W-1:0] op_q,
  input logic [$clog2(DEPTH+1)-1:0] fill_cnt,
  input logic [$clog2(DEPTH+1)-1:0] sent_cnt
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] LAST = CW'(DEPTH);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!s_ready && !m_valid));

  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_cnt <= LAST) && (sent_cnt <= LAST));

  p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_complete_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(fill_cnt) == LAST && $past(sent_cnt) == LAST && !busy));

  // R8: a start while busy must not re-latch the configuration
  p_cfg_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(fill_sel) && $stable(op_q)));
endmodule

bind pingpong_addbuf pingpong_addbuf_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .s_ready(s_ready),
  .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .fill_sel(fill_sel),
  .op_q(op_q), .fill_cnt(fill_cnt), .sent_cnt(sent_cnt)
);

// File: tb/tb_pingpong_addbuf.sv
module tb_pingpong_addbuf;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic inv_lsb = 1'b0;
  logic [DATA_W-1:0] operand = '0;
  logic busy, done, s_ready, m_valid;
  logic [DATA_W-1:0] s_data = '0;
  logic s_valid = 1'b0;
  logic [DATA_W-1:0] m_data;
  logic m_ready = 1'b0;

  pingpong_addbuf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .inv_lsb(inv_lsb), .operand(operand),
    .busy(busy), .done(done), .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
    .m_data(m_data), .m_valid(m_valid), .m_ready(m_ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails = 0;

  logic [DATA_W-1:0] in_q[$];
  logic [DATA_W-1:0] exp_q[$];
  bit                exp_ok_q[$];
  logic [DATA_W-1:0] model [2][DEPTH];
  bit                model_ok [2] = '{0, 0};

  bit in_gaps = 0, out_gaps = 0, prev_stall = 0, extra_ready = 0;
  logic [DATA_W-1:0] prev_data = '0;
  int acc_inv = 0, sent_inv = 0, done_seen = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // stream driver and scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) check(m_valid && m_data == prev_data, "R6", m_data, prev_data);
      m_ready = out_gaps ? (lfsr[0] | lfsr[4]) : 1'b1;
      if (m_valid && m_ready) begin
        sent_inv++;
        if (exp_q.size() == 0) check(0, "R4", sent_inv, DEPTH);
        else begin
          logic [DATA_W-1:0] e;
          bit ok;
          e = exp_q.pop_front();
          ok = exp_ok_q.pop_front();
          if (ok) check(m_data == e, "R2,R3,R5,R11", m_data, e);
        end
      end
      prev_stall = m_valid && !m_ready;
      prev_data = m_data;
      if (busy && in_q.size() == 0 && s_ready) extra_ready = 1;
      s_valid = (in_q.size() > 0) && (in_gaps ? lfsr[2] : 1'b1);
      s_data = (in_q.size() > 0) ? in_q[0] : '0;
      if (s_valid && s_ready) begin
        void'(in_q.pop_front());
        acc_inv++;
      end
      if (done) done_seen++;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end
  end

  task automatic run_inv(input logic [DATA_W-1:0] idx, input logic [DATA_W-1:0] op,
                         input bit ig, input bit og, input bit glitch, input bit timed);
    int fb, db, cyc;
    logic [DATA_W-1:0] w;
    fb = int'(idx[0]);
    db = 1 - fb;
    for (int i = 0; i < DEPTH; i++) begin
      exp_q.push_back(model[db][i] + op);
      exp_ok_q.push_back(model_ok[db]);
    end
    for (int i = 0; i < DEPTH; i++) begin
      w = (idx * 32'h0100_0193) ^ (32'(i) * 32'h9E37_79B1);
      if (i == 0) w = 32'hFFFF_FFFF;
      in_q.push_back(w);
      model[fb][i] = w;
    end
    model_ok[fb] = 1;
    in_gaps = ig; out_gaps = og;
    acc_inv = 0; sent_inv = 0; done_seen = 0; extra_ready = 0;
    @(negedge clk);
    start = 1'b1; inv_lsb = idx[0]; operand = op;
    @(negedge clk);
    start = 1'b0; inv_lsb = ~idx[0]; operand = op ^ 32'h5A5A_A5A5;
    cyc = 1;
    while (done_seen == 0 && cyc < 50000) begin
      @(negedge clk);
      cyc++;
      if (glitch && cyc == 200) begin start = 1'b1; inv_lsb = idx[0] ^ 1'b1; operand = 32'h1234_5678; end
      if (glitch && cyc == 201) start = 1'b0;
    end
    if (timed) check(cyc >= DEPTH && cyc <= DEPTH + 4, "R10", cyc, DEPTH + 3);
    check(done_seen == 1, "R7", done_seen, 1);
    @(negedge clk);
    @(negedge clk);
    check(!done && !busy, "R7", {done, busy}, 0);
    check(done_seen == 1, "R7 R8", done_seen, 1);
    check(acc_inv == DEPTH, "R4", acc_inv, DEPTH);
    check(sent_inv == DEPTH && exp_q.size() == 0, "R4", sent_inv, DEPTH);
    check(!extra_ready, "R4", extra_ready, 0);
    if (glitch) check(!busy, "R8", busy, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !s_ready && !m_valid, "R1", {busy, done, s_ready, m_valid}, 0);
    run_inv(32'd0, 32'd5,          0, 0, 0, 1);
    run_inv(32'd1, 32'hFFFF_FFFF,  1, 1, 1, 0);
    run_inv(32'd2, 32'h8000_0000,  0, 1, 0, 0);
    run_inv(32'd7, 32'd3,          0, 0, 0, 1);
    run_inv(32'd9, 32'h0000_0100,  1, 0, 0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule